// File: doc/BRIEF.md
# Four-Switch Buck-Boost PWM Generator

This block produces the four gate-drive signals of a single-inductor, four-switch buck-boost power stage. Each leg has a high-side and a low-side switch: one leg forms the buck leg and one the boost leg. A free-running carrier counter is compared with a duty command. The command comes either from a tracking control loop or from a fixed open-loop test value. The result drives whichever leg the selected conversion region modulates, and the other leg is parked with its high side on. A small state machine per leg inserts a programmable turn-on and turn-off dead time, so the two switches of a leg are never on together.

The duty command carries more bits than the carrier counter. The extra low-order bits are dithered across consecutive carrier periods to gain resolution. Duty and region are sampled only at the end of a carrier period. The open-loop selection is honoured only when a soft reset is released. The active-low reset and the soft reset both force every gate output low.

Top module: `fsbb_pwm`

## Requirements
- R1: Within each leg the high-side and low-side outputs are never high in the same clock cycle.
- R2: Before the high side of a leg rises, both outputs of that leg stay low for max(dt_on,1) cycles. Before the low side rises, both stay low for max(dt_off,1) cycles. A side never rises in the cycle after the other side was high.
- R3: The carrier period is 2^(DUTY_W-DITH_W) cycles. For a period compare value c with 0<c<period, the modulating leg has its high side on for c-max(dt_on,1) cycles and its low side on for (period-c)-max(dt_off,1) cycles per period. With c=0 the low side stays on continuously.
- R4: The compare value c is the upper DUTY_W-DITH_W bits of the duty. One is added in the carrier periods whose index k satisfies (k mod 2^DITH_W) < duty[DITH_W-1:0], where k counts period boundaries since reset.
- R5: region 0 (buck) modulates the buck leg and holds the boost high side on. Region 1 (boost) modulates the boost leg and holds the buck high side on. Regions 2 and 3 (pass-through) hold both high sides on.
- R6: Duty and region are captured only at the last cycle of a carrier period, so a change in mid-period never shortens or stretches the pulse in progress.
- R7: open_loop_sel chooses ol_duty instead of loop_duty only from the release of a soft reset onward, and a later change of open_loop_sel takes effect only at the next soft-reset release.
- R8: While soft_rst is high, all four outputs are low from the next cycle on, and the carrier restarts when soft_rst is released.
- R9: While rst_n is low, all four outputs are low without waiting for a clock edge.
- R10: A high-side demand shorter than the turn-on dead time produces no high-side pulse.
- R11: A compare value equal to the full period keeps the high side on for the whole period. A single-cycle dip in demand, as dithering produces at the top of the range, turns the high side off for 1+max(dt_on,1) cycles and leaves the low side off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; forces all outputs low |
| soft_rst | input | 1 | Synchronous soft reset, active high; holds outputs low and restarts the carrier |
| open_loop_sel | input | 1 | Requests the open-loop duty source; sampled at soft-reset release |
| loop_duty | input | DUTY_W | Duty command from the tracking loop |
| ol_duty | input | DUTY_W | Open-loop duty command |
| region | input | 2 | Conversion region: 0 buck, 1 boost, 2 or 3 pass-through |
| dt_on | input | DT_W | Turn-on dead time in cycles, applied before a high side rises |
| dt_off | input | DT_W | Turn-off dead time in cycles, applied before a low side rises |
| buck_hs | output | 1 | Buck leg high-side gate |
| buck_ls | output | 1 | Buck leg low-side gate |
| boost_hs | output | 1 | Boost leg high-side gate |
| boost_ls | output | 1 | Boost leg low-side gate |

## Verification
A reversal of leg demand can coincide with a dead-time countdown still in progress. The leg state machine must then abandon the wait and start the opposite one without ever letting a side through. The bench provokes this with a duty two carrier steps long against a three-cycle turn-on dead time. It also uses the highest dithered duty, where demand drops for exactly one cycle at the period boundary. Both cases are judged by the exact high and low cycle counts over four periods, and a bench monitor checks every sample for overlap and for a side rising straight after the other.

// File: rtl/fsbb_pkg.sv
package fsbb_pkg;

    typedef enum logic [1:0] {
        RGN_BUCK  = 2'd0,
        RGN_BOOST = 2'd1,
        RGN_PASS  = 2'd2,
        RGN_PASS2 = 2'd3
    } rgn_e;

    typedef enum logic [2:0] {
        LEG_IDLE,
        LEG_HI_WAIT,
        LEG_HI_ON,
        LEG_LO_WAIT,
        LEG_LO_ON
    } leg_st_e;

    typedef enum logic {
        CTL_RUN,
        CTL_HOLD
    } ctl_st_e;

endpackage

// File: rtl/fsbb_carrier.sv
module fsbb_carrier #(
    parameter int CNT_W  = 8,
    parameter int DITH_W = 1,
    parameter int PH_W   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic [PH_W-1:0]  phase
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign wrap = &cnt;

    generate
        if (DITH_W > 0) begin : g_phase
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    phase <= '0;
                end else if (clr) begin
                    phase <= '0;
                end else if (wrap) begin
                    phase <= phase + 1'b1;
                end
            end
        end else begin : g_no_phase
            assign phase = '0;
        end
    endgenerate

endmodule

// File: rtl/fsbb_duty_latch.sv
module fsbb_duty_latch
    import fsbb_pkg::*;
#(
    parameter int DUTY_W = 9,
    parameter int DITH_W = 1,
    parameter int CNT_W  = 8,
    parameter int PH_W   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [DUTY_W-1:0] duty,
    input  logic [1:0]        region,
    input  logic [PH_W-1:0]   phase,
    output logic [CNT_W:0]    cmp,
    output rgn_e              rgn
);

    localparam int CMP_W = CNT_W + 1;

    logic [CNT_W:0] cmp_d;

    generate
        if (DITH_W > 0) begin : g_dither
            logic extra;
            assign extra = (phase < duty[DITH_W-1:0]);
            assign cmp_d = {1'b0, duty[DUTY_W-1:DITH_W]} + CMP_W'(extra);
        end else begin : g_plain
            logic unused_phase;
            assign unused_phase = ^phase;
            assign cmp_d = {1'b0, duty};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp <= '0;
            rgn <= RGN_BUCK;
        end else if (clr) begin
            cmp <= '0;
            rgn <= RGN_BUCK;
        end else if (load) begin
            cmp <= cmp_d;
            rgn <= rgn_e'(region);
        end
    end

endmodule

// File: rtl/fsbb_leg.sv
module fsbb_leg
    import fsbb_pkg::*;
#(
    parameter int DT_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            halt,
    input  logic            demand,
    input  logic [DT_W-1:0] dt_on,
    input  logic [DT_W-1:0] dt_off,
    output logic            hs,
    output logic            ls
);

    leg_st_e         st_q, st_d;
    logic [DT_W-1:0] tmr_q, tmr_d;
    logic            tmr_done;

    assign tmr_done = (tmr_q <= DT_W'(1));

    // next state and dead-time timer
    always_comb begin
        st_d  = st_q;
        tmr_d = tmr_q;
        if (halt) begin
            st_d  = LEG_IDLE;
            tmr_d = '0;
        end else begin
            unique case (st_q)
                LEG_IDLE: begin
                    if (demand) begin
                        st_d  = LEG_HI_WAIT;
                        tmr_d = dt_on;
                    end else begin
                        st_d  = LEG_LO_WAIT;
                        tmr_d = dt_off;
                    end
                end
                LEG_HI_WAIT: begin
                    if (!demand) begin
                        st_d  = LEG_LO_WAIT;
                        tmr_d = dt_off;
                    end else if (tmr_done) begin
                        st_d = LEG_HI_ON;
                    end else begin
                        tmr_d = tmr_q - 1'b1;
                    end
                end
                LEG_HI_ON: begin
                    if (!demand) begin
                        st_d  = LEG_LO_WAIT;
                        tmr_d = dt_off;
                    end
                end
                LEG_LO_WAIT: begin
                    if (demand) begin
                        st_d  = LEG_HI_WAIT;
                        tmr_d = dt_on;
                    end else if (tmr_done) begin
                        st_d = LEG_LO_ON;
                    end else begin
                        tmr_d = tmr_q - 1'b1;
                    end
                end
                LEG_LO_ON: begin
                    if (demand) begin
                        st_d  = LEG_HI_WAIT;
                        tmr_d = dt_on;
                    end
                end
                default: begin
                    st_d  = LEG_IDLE;
                    tmr_d = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= LEG_IDLE;
            tmr_q <= '0;
        end else begin
            st_q  <= st_d;
            tmr_q <= tmr_d;
        end
    end

    // outputs decoded from the registered state
    always_comb begin
        hs = 1'b0;
        ls = 1'b0;
        unique case (st_q)
            LEG_HI_ON: hs = 1'b1;
            LEG_LO_ON: ls = 1'b1;
            default: begin
                hs = 1'b0;
                ls = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/fsbb_pwm.sv
module fsbb_pwm
    import fsbb_pkg::*;
#(
    parameter int DUTY_W = 9,
    parameter int DITH_W = 1,
    parameter int DT_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              open_loop_sel,
    input  logic [DUTY_W-1:0] loop_duty,
    input  logic [DUTY_W-1:0] ol_duty,
    input  logic [1:0]        region,
    input  logic [DT_W-1:0]   dt_on,
    input  logic [DT_W-1:0]   dt_off,
    output logic              buck_hs,
    output logic              buck_ls,
    output logic              boost_hs,
    output logic              boost_ls
);

    localparam int CNT_W  = DUTY_W - DITH_W;
    localparam int PH_W   = (DITH_W > 0) ? DITH_W : 1;
    localparam int N_LEGS = 2;

    ctl_st_e           ctl_q, ctl_d;
    logic              ol_mode_q;
    logic              halt;
    logic [DUTY_W-1:0] duty_sel;
    logic [CNT_W-1:0]  cnt;
    logic              wrap;
    logic [PH_W-1:0]   phase;
    logic [CNT_W:0]    cmp;
    rgn_e              rgn;
    logic              pwm;
    logic [N_LEGS-1:0] dem;
    logic [N_LEGS-1:0] hs;
    logic [N_LEGS-1:0] ls;

    // soft-reset control state machine
    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q)
            CTL_RUN:  if (soft_rst)  ctl_d = CTL_HOLD;
            CTL_HOLD: if (!soft_rst) ctl_d = CTL_RUN;
            default:  ctl_d = CTL_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q     <= CTL_RUN;
            ol_mode_q <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
            if (ctl_q == CTL_HOLD && !soft_rst) begin
                ol_mode_q <= open_loop_sel;
            end
        end
    end

    assign halt     = soft_rst | (ctl_q == CTL_HOLD);
    assign duty_sel = ol_mode_q ? ol_duty : loop_duty;

    fsbb_carrier #(
        .CNT_W  (CNT_W),
        .DITH_W (DITH_W),
        .PH_W   (PH_W)
    ) u_carrier (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (halt),
        .cnt   (cnt),
        .wrap  (wrap),
        .phase (phase)
    );

    fsbb_duty_latch #(
        .DUTY_W (DUTY_W),
        .DITH_W (DITH_W),
        .CNT_W  (CNT_W),
        .PH_W   (PH_W)
    ) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (halt),
        .load   (wrap),
        .duty   (duty_sel),
        .region (region),
        .phase  (phase),
        .cmp    (cmp),
        .rgn    (rgn)
    );

    assign pwm    = ({1'b0, cnt} < cmp);
    assign dem[0] = (rgn == RGN_BUCK)  ? pwm : 1'b1;
    assign dem[1] = (rgn == RGN_BOOST) ? pwm : 1'b1;

    generate
        for (genvar g = 0; g < N_LEGS; g++) begin : g_leg
            fsbb_leg #(
                .DT_W (DT_W)
            ) u_leg (
                .clk    (clk),
                .rst_n  (rst_n),
                .halt   (halt),
                .demand (dem[g]),
                .dt_on  (dt_on),
                .dt_off (dt_off),
                .hs     (hs[g]),
                .ls     (ls[g])
            );
        end
    endgenerate

    assign buck_hs  = hs[0];
    assign buck_ls  = ls[0];
    assign boost_hs = hs[1];
    assign boost_ls = ls[1];

endmodule

// File: rtl/fsbb_pwm_chk.sv
module fsbb_pwm_chk (
    input logic clk,
    input logic rst_n,
    input logic soft_rst,
    input logic buck_hs,
    input logic buck_ls,
    input logic boost_hs,
    input logic boost_ls,
    input logic ol_mode
);

    assert_buck_no_overlap_R1: assert property (
        @(posedge clk) disable iff (!rst_n) !(buck_hs && buck_ls));

    assert_boost_no_overlap_R1: assert property (
        @(posedge clk) disable iff (!rst_n) !(boost_hs && boost_ls));

    assert_buck_hs_gap_R2: assert property (
        @(posedge clk) disable iff (!rst_n) $rose(buck_hs) |-> !$past(buck_ls));

    assert_buck_ls_gap_R2: assert property (
        @(posedge clk) disable iff (!rst_n) $rose(buck_ls) |-> !$past(buck_hs));

    assert_boost_hs_gap_R2: assert property (
        @(posedge clk) disable iff (!rst_n) $rose(boost_hs) |-> !$past(boost_ls));

    assert_boost_ls_gap_R2: assert property (
        @(posedge clk) disable iff (!rst_n) $rose(boost_ls) |-> !$past(boost_hs));

    assert_soft_off_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        soft_rst |=> !(buck_hs || buck_ls || boost_hs || boost_ls));

    assert_ol_mode_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        !$stable(ol_mode) |-> ($past(soft_rst, 2) && !$past(soft_rst)));

endmodule

bind fsbb_pwm fsbb_pwm_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .buck_hs  (buck_hs),
    .buck_ls  (buck_ls),
    .boost_hs (boost_hs),
    .boost_ls (boost_ls),
    .ol_mode  (ol_mode_q)
);

// File: tb/fsbb_pwm_bench.sv
module fsbb_pwm_bench;

    localparam int DW = 6;
    localparam int XW = 1;
    localparam int TW = 3;
    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          soft_rst;
    logic          open_loop_sel;
    logic [DW-1:0] loop_duty;
    logic [DW-1:0] ol_duty;
    logic [1:0]    region;
    logic [TW-1:0] dt_on;
    logic [TW-1:0] dt_off;
    logic          buck_hs, buck_ls, boost_hs, boost_ls;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    fsbb_pwm #(
        .DUTY_W (DW),
        .DITH_W (XW),
        .DT_W   (TW)
    ) u_fsbb_pwm (
        .clk           (clk),
        .rst_n         (rst_n),
        .soft_rst      (soft_rst),
        .open_loop_sel (open_loop_sel),
        .loop_duty     (loop_duty),
        .ol_duty       (ol_duty),
        .region        (region),
        .dt_on         (dt_on),
        .dt_off        (dt_off),
        .buck_hs       (buck_hs),
        .buck_ls       (buck_ls),
        .boost_hs      (boost_hs),
        .boost_ls      (boost_ls)
    );

    typedef struct packed {
        logic [1:0] rg;
        logic [5:0] du;
        logic [2:0] on;
        logic [2:0] off;
        logic [7:0] bh;
        logic [7:0] bl;
        logic [7:0] oh;
        logic [7:0] ol;
    } vec_t;

    // expected high/low cycle counts over four carrier periods
    localparam vec_t VEC [9] = '{
        '{2'd0, 6'd20, 3'd3, 3'd3, 8'd28,  8'd76,  8'd128, 8'd0},  // R3 R5 buck
        '{2'd0, 6'd21, 3'd3, 3'd3, 8'd30,  8'd74,  8'd128, 8'd0},  // R4 dither
        '{2'd1, 6'd40, 3'd1, 3'd2, 8'd128, 8'd0,   8'd76,  8'd40}, // R5 boost
        '{2'd2, 6'd40, 3'd1, 3'd2, 8'd128, 8'd0,   8'd128, 8'd0},  // R5 pass
        '{2'd3, 6'd10, 3'd3, 3'd3, 8'd128, 8'd0,   8'd128, 8'd0},  // R5 pass alt
        '{2'd0, 6'd0,  3'd3, 3'd3, 8'd0,   8'd128, 8'd128, 8'd0},  // R3 zero
        '{2'd0, 6'd63, 3'd3, 3'd3, 8'd120, 8'd0,   8'd128, 8'd0},  // R11 top
        '{2'd0, 6'd20, 3'd0, 3'd0, 8'd36,  8'd84,  8'd128, 8'd0},  // R2 zero dt
        '{2'd0, 6'd4,  3'd3, 3'd3, 8'd0,   8'd108, 8'd128, 8'd0}   // R10 abort
    };

    task automatic check(input bit ok, input string msg);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic settle();
        repeat (3 * NP) @(negedge clk);
    endtask

    task automatic measure(output int bh, output int bl, output int oh, output int ol);
        bh = 0; bl = 0; oh = 0; ol = 0;
        repeat (4 * NP) begin
            @(negedge clk);
            bh += int'(buck_hs);
            bl += int'(buck_ls);
            oh += int'(boost_hs);
            ol += int'(boost_ls);
        end
    endtask

    task automatic pulse_soft();
        @(negedge clk);
        soft_rst = 1'b1;
        repeat (2) @(negedge clk);
        check(!(buck_hs || buck_ls || boost_hs || boost_ls),
              $sformatf("R8 outputs during soft reset act=%b%b%b%b exp=0000",
                        buck_hs, buck_ls, boost_hs, boost_ls));
        repeat (5) @(negedge clk);
        soft_rst = 1'b0;
    endtask

    // overlap, gap and pulse-length monitors
    int   ovl_err = 0;
    int   gap_err = 0;
    logic p_bh = 1'b0, p_bl = 1'b0, p_oh = 1'b0, p_ol = 1'b0;
    bit   mon_en = 1'b0;
    bit   started = 1'b0;
    int   run_len = 0;
    int   pulses = 0;
    int   bad_pulses = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if ((buck_hs && buck_ls) || (boost_hs && boost_ls)) ovl_err++;
            if ((buck_hs && !p_bh && p_bl) || (buck_ls && !p_bl && p_bh)) gap_err++;
            if ((boost_hs && !p_oh && p_ol) || (boost_ls && !p_ol && p_oh)) gap_err++;
        end
        if (mon_en) begin
            if (buck_hs && !p_bh) begin
                started = 1'b1;
                run_len = 1;
            end else if (buck_hs) begin
                run_len++;
            end else if (p_bh && started) begin
                pulses++;
                if (run_len != 7 && run_len != 17) begin
                    bad_pulses++;
                    $display("R6 pulse length %0d", run_len);
                end
            end
        end else begin
            started = 1'b0;
        end
        p_bh = buck_hs;
        p_bl = buck_ls;
        p_oh = boost_hs;
        p_ol = boost_ls;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        int bh, bl, oh, ol;
        rst_n         = 1'b0;
        soft_rst      = 1'b0;
        open_loop_sel = 1'b0;
        loop_duty     = '0;
        ol_duty       = '0;
        region        = 2'd0;
        dt_on         = 3'd3;
        dt_off        = 3'd3;
        repeat (3) @(negedge clk);
        // R9: reset state
        check({buck_hs, buck_ls, boost_hs, boost_ls} == 4'b0000,
              $sformatf("R9 reset outputs act=%b%b%b%b exp=0000",
                        buck_hs, buck_ls, boost_hs, boost_ls));
        rst_n = 1'b1;

        // table of vectors: R2 R3 R4 R5 R10 R11
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            region    = VEC[i].rg;
            loop_duty = VEC[i].du;
            dt_on     = VEC[i].on;
            dt_off    = VEC[i].off;
            settle();
            measure(bh, bl, oh, ol);
            check(bh == int'(VEC[i].bh) && bl == int'(VEC[i].bl) &&
                  oh == int'(VEC[i].oh) && ol == int'(VEC[i].ol),
                  $sformatf("R3/R5 row %0d act=%0d,%0d,%0d,%0d exp=%0d,%0d,%0d,%0d",
                            i, bh, bl, oh, ol, VEC[i].bh, VEC[i].bl, VEC[i].oh, VEC[i].ol));
        end

        // R7: open-loop selection waits for soft-reset release
        @(negedge clk);
        region        = 2'd0;
        dt_on         = 3'd3;
        dt_off        = 3'd3;
        loop_duty     = 6'd40;
        ol_duty       = 6'd20;
        open_loop_sel = 1'b1;
        settle();
        measure(bh, bl, oh, ol);
        check(bh == 68 && bl == 36,
              $sformatf("R7 before soft reset act=%0d,%0d exp=68,36", bh, bl));
        pulse_soft();
        settle();
        measure(bh, bl, oh, ol);
        check(bh == 28 && bl == 76,
              $sformatf("R7 open loop active act=%0d,%0d exp=28,76", bh, bl));
        @(negedge clk);
        open_loop_sel = 1'b0;
        settle();
        measure(bh, bl, oh, ol);
        check(bh == 28 && bl == 76,
              $sformatf("R7 select change held act=%0d,%0d exp=28,76", bh, bl));
        pulse_soft();
        settle();
        measure(bh, bl, oh, ol);
        check(bh == 68 && bl == 36 && oh == 128 && ol == 0,
              $sformatf("R8 R7 restart closed loop act=%0d,%0d,%0d,%0d exp=68,36,128,0",
                        bh, bl, oh, ol));

        // R6: mid-period duty changes never produce odd pulse lengths
        @(negedge clk);
        loop_duty = 6'd20;
        settle();
        mon_en = 1'b1;
        for (int k = 0; k < 8; k++) begin
            repeat (29 + k * 5) @(negedge clk);
            loop_duty = (loop_duty == 6'd20) ? 6'd40 : 6'd20;
        end
        settle();
        mon_en = 1'b0;
        check(bad_pulses == 0 && pulses >= 8,
              $sformatf("R6 pulse lengths act=bad%0d/n%0d exp=bad0/n>=8", bad_pulses, pulses));

        // R9: asynchronous reset between clock edges
        @(negedge clk);
        #1 rst_n = 1'b0;
        #0.5;
        check({buck_hs, buck_ls, boost_hs, boost_ls} == 4'b0000,
              $sformatf("R9 async reset act=%b%b%b%b exp=0000",
                        buck_hs, buck_ls, boost_hs, boost_ls));
        @(negedge clk);
        rst_n = 1'b1;
        settle();

        check(ovl_err == 0, $sformatf("R1 overlap samples act=%0d exp=0", ovl_err));
        check(gap_err == 0, $sformatf("R2 missing dead gap act=%0d exp=0", gap_err));

        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule